// File: doc/BRIEF.md
# USB Frame Interval Timer

This block produces the frame timing of a USB host controller. A 14-bit down-counter, advanced by a 12 MHz bit-time strobe, counts out each frame. It is reloaded from a programmable interval value, so the nominal setting of 11999 gives 12000 bit times, or 1 ms, per frame. At each frame boundary the block raises a one-cycle start-of-frame pulse, advances a 16-bit frame number and copies the interval register's toggle bit into the remaining register. The host uses that toggle bit to tell frames of the old length from frames of a new one.

Software programs the interval, the periodic-start point and the low-speed threshold through a single write/read register port. It can read the live frame-remaining count and the frame number there, but it cannot write them. The counter advances only while the controller's functional state input says operational. Suspend and resume freeze it, and the reset state clears it. A sticky flag marks every change of the frame number's top bit, which lets software extend the frame number beyond 16 bits.

Top module: `usb_frame_timer`

## Requirements
- R1: After the synchronous reset the interval register reads 0x00002EDF (interval 11999, toggle 0). Remaining, frame number, periodic start and low-speed threshold read 0. The start-of-frame pulse and the top-bit flag are low.
- R2: A write to the interval register (address 0) stores bits 31:16 and 13:0 and forces bits 15:14 to zero. Bits 13:0 are the interval and bit 31 is the toggle.
- R3: A write to periodic start (address 3) keeps only bits 13:0. A write to the low-speed threshold (address 4) keeps only bits 11:0. All higher bits read as zero.
- R4: Writes to frame remaining (address 1) and frame number (address 2) change nothing.
- R5: On the clock where the state input first reads operational (encoding 2), the remaining count loads the interval value. After that it falls by one on each clock with the bit strobe high and holds when the strobe is low.
- R6: On a strobed clock with remaining at 0, the count reloads from the interval value held at that moment, so a frame lasts interval+1 strobes. A new interval written mid-frame takes effect only at the next reload. The start-of-frame output is high for exactly the cycle following each reload.
- R7: At each reload, bit 31 of frame remaining takes the value of bit 31 of the interval register.
- R8: At each reload the frame number advances by one, modulo 2^16.
- R9: The top-bit flag sets whenever frame number bit 15 changes through an increment. It stays set until the acknowledge input is high on a clock, and a set on the same clock wins over the acknowledge.
- R10: In suspend (3) or resume (1) the remaining count, the toggle and the frame number hold and no start-of-frame pulse occurs. In the reset state (0) the remaining count, the toggle and the frame number clear to zero.
- R11: The read port is combinational: address 0 interval, 1 remaining (count in 13:0, toggle in 31), 2 frame number in 15:0, 3 periodic start, 4 threshold. Addresses 5 to 7 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_state | input | 2 | Controller functional state: 0 reset, 1 resume, 2 operational, 3 suspend |
| bit_tick | input | 1 | Bit-time strobe at 12 MHz |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for write and read |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for reg_addr |
| ovf_ack | input | 1 | Clears the top-bit flag |
| sof_pulse | output | 1 | One-cycle start-of-frame event |
| fn_msb_flag | output | 1 | Sticky flag: frame number bit 15 changed |

## Verification
Any error in the down-counter appears at once in the remaining readback. It also shifts the next start-of-frame pulse by the same number of strobes, so a wrong reload value or off-by-one shows within one frame of the fault. A toggle or frame-number fault appears at the first boundary, as a wrong bit 31 or a missed increment. A flag fault takes 32768 frames to show, so the bench runs with an interval of 0, which gives one boundary per strobe, and walks the frame number through both flips of bit 15.

// File: rtl/ufr_pkg.sv
package ufr_pkg;

    localparam int DW     = 32;
    localparam int AW     = 3;
    localparam int FI_W   = 14;
    localparam int PKT_W  = 15;
    localparam int FN_W   = 16;
    localparam int PS_W   = 14;
    localparam int LST_W  = 12;

    typedef enum logic [1:0] {
        ST_RESET   = 2'd0,
        ST_RESUME  = 2'd1,
        ST_OPER    = 2'd2,
        ST_SUSPEND = 2'd3
    } hc_state_e;

    localparam logic [AW-1:0] A_INTERVAL = 3'd0;
    localparam logic [AW-1:0] A_REMAIN   = 3'd1;
    localparam logic [AW-1:0] A_NUMBER   = 3'd2;
    localparam logic [AW-1:0] A_PSTART   = 3'd3;
    localparam logic [AW-1:0] A_LSTHR    = 3'd4;

    typedef struct packed {
        logic             tgl;
        logic [PKT_W-1:0] pkt_max;
        logic [FI_W-1:0]  span;
    } interval_t;

    typedef struct packed {
        logic            tgl;
        logic [FI_W-1:0] cnt;
    } remain_t;

    function automatic interval_t word_to_interval(input logic [DW-1:0] w);
        interval_t r;
        r.tgl     = w[31];
        r.pkt_max = w[30:16];
        r.span    = w[FI_W-1:0];
        return r;
    endfunction

    function automatic logic [DW-1:0] interval_to_word(input interval_t iv);
        return {iv.tgl, iv.pkt_max, 2'b00, iv.span};
    endfunction

    function automatic logic [DW-1:0] remain_to_word(input remain_t rm);
        return {rm.tgl, {(DW-1-FI_W){1'b0}}, rm.cnt};
    endfunction

endpackage

// File: rtl/ufr_regs.sv
module ufr_regs
    import ufr_pkg::*;
#(
    parameter logic [FI_W-1:0]  FI_RESET  = 14'd11999,
    parameter logic [PS_W-1:0]  PS_RESET  = '0,
    parameter logic [LST_W-1:0] LST_RESET = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    output interval_t        iv_q,
    output logic [PS_W-1:0]  ps_q,
    output logic [LST_W-1:0] lst_q
);

    logic unused_rsvd;
    assign unused_rsvd = ^wr_data[15:14];

    always_ff @(posedge clk) begin
        if (rst) begin
            iv_q.tgl     <= 1'b0;
            iv_q.pkt_max <= '0;
            iv_q.span    <= FI_RESET;
            ps_q         <= PS_RESET;
            lst_q        <= LST_RESET;
        end else if (wr_en) begin
            case (wr_addr)
                A_INTERVAL: iv_q  <= word_to_interval(wr_data);
                A_PSTART:   ps_q  <= wr_data[PS_W-1:0];
                A_LSTHR:    lst_q <= wr_data[LST_W-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ufr_counter.sv
module ufr_counter
    import ufr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  hc_state_e       state,
    input  logic            bit_tick,
    input  logic [FI_W-1:0] span,
    input  logic            span_tgl,
    output remain_t         rem_q,
    output logic            wrap,
    output logic            sof_q
);

    logic was_oper;
    logic oper;

    assign oper = (state == ST_OPER);
    assign wrap = oper && was_oper && bit_tick && (rem_q.cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q    <= '0;
            was_oper <= 1'b0;
            sof_q    <= 1'b0;
        end else begin
            was_oper <= oper;
            sof_q    <= wrap;
            if (state == ST_RESET) begin
                rem_q <= '0;
            end else if (oper && !was_oper) begin
                rem_q.cnt <= span;
            end else if (wrap) begin
                rem_q.cnt <= span;
                rem_q.tgl <= span_tgl;
            end else if (oper && bit_tick) begin
                rem_q.cnt <= rem_q.cnt - {{(FI_W-1){1'b0}}, 1'b1};
            end
        end
    end

endmodule

// File: rtl/ufr_fnum.sv
module ufr_fnum
    import ufr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            adv,
    input  logic            ack,
    output logic [FN_W-1:0] fn_q,
    output logic            flag_q
);

    logic [FN_W-1:0] fn_nxt;
    logic            top_flip;

    assign fn_nxt   = fn_q + {{(FN_W-1){1'b0}}, 1'b1};
    assign top_flip = adv && !clear && (fn_nxt[FN_W-1] != fn_q[FN_W-1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            fn_q   <= '0;
            flag_q <= 1'b0;
        end else begin
            if (clear)
                fn_q <= '0;
            else if (adv)
                fn_q <= fn_nxt;

            if (top_flip)
                flag_q <= 1'b1;
            else if (ack)
                flag_q <= 1'b0;
        end
    end

endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer
    import ufr_pkg::*;
#(
    parameter logic [FI_W-1:0]  FI_RESET  = 14'd11999,
    parameter logic [PS_W-1:0]  PS_RESET  = '0,
    parameter logic [LST_W-1:0] LST_RESET = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    run_state,
    input  logic          bit_tick,
    input  logic          wr_en,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    input  logic          ovf_ack,
    output logic          sof_pulse,
    output logic          fn_msb_flag
);

    hc_state_e        state;
    interval_t        iv;
    logic [PS_W-1:0]  ps;
    logic [LST_W-1:0] lst;
    remain_t          rem;
    logic             wrap;
    logic [FN_W-1:0]  frame_num;

    assign state = hc_state_e'(run_state);

    ufr_regs #(
        .FI_RESET (FI_RESET),
        .PS_RESET (PS_RESET),
        .LST_RESET(LST_RESET)
    ) i_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_addr(reg_addr),
        .wr_data(wr_data),
        .iv_q   (iv),
        .ps_q   (ps),
        .lst_q  (lst)
    );

    ufr_counter i_cnt (
        .clk     (clk),
        .rst     (rst),
        .state   (state),
        .bit_tick(bit_tick),
        .span    (iv.span),
        .span_tgl(iv.tgl),
        .rem_q   (rem),
        .wrap    (wrap),
        .sof_q   (sof_pulse)
    );

    ufr_fnum i_fn (
        .clk   (clk),
        .rst   (rst),
        .clear (state == ST_RESET),
        .adv   (wrap),
        .ack   (ovf_ack),
        .fn_q  (frame_num),
        .flag_q(fn_msb_flag)
    );

    always_comb begin
        case (reg_addr)
            A_INTERVAL: rd_data = interval_to_word(iv);
            A_REMAIN:   rd_data = remain_to_word(rem);
            A_NUMBER:   rd_data = {{(DW-FN_W){1'b0}}, frame_num};
            A_PSTART:   rd_data = {{(DW-PS_W){1'b0}}, ps};
            A_LSTHR:    rd_data = {{(DW-LST_W){1'b0}}, lst};
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/ufr_checker.sv
module ufr_checker
    import ufr_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [1:0]      run_state,
    input logic            bit_tick,
    input logic            ovf_ack,
    input logic            sof_pulse,
    input logic            fn_msb_flag,
    input remain_t         rem,
    input interval_t       iv,
    input logic [FN_W-1:0] frame_num
);

    // R6: a start-of-frame cycle shows the count freshly reloaded from the previous interval
    a_r6_sof_reload: assert property (@(posedge clk) disable iff (rst)
        sof_pulse |-> rem.cnt == $past(iv.span));

    // R7: toggle copied at the boundary
    a_r7_toggle_copy: assert property (@(posedge clk) disable iff (rst)
        sof_pulse |-> rem.tgl == $past(iv.tgl));

    // R8: frame number steps by one with each start of frame
    a_r8_fn_step: assert property (@(posedge clk) disable iff (rst)
        sof_pulse |-> frame_num == $past(frame_num) + 16'd1);

    // R10: no frame event after a non-operational cycle
    a_r10_no_sof_idle: assert property (@(posedge clk) disable iff (rst)
        (run_state != 2'd2) |=> !sof_pulse);

    // R10: suspend freezes the count and the frame number
    a_r10_suspend_hold: assert property (@(posedge clk) disable iff (rst)
        (run_state == 2'd3) |=> ($stable(rem) && $stable(frame_num)));

    // R9: flag holds without an acknowledge
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (fn_msb_flag && !ovf_ack) |=> fn_msb_flag);

    // R9: a change of the top bit through counting raises the flag
    a_r9_flag_set: assert property (@(posedge clk) disable iff (rst)
        (sof_pulse && !$stable(frame_num[FN_W-1])) |-> fn_msb_flag);

    // R5: strobe low while operational keeps the count
    a_r5_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
        (run_state == 2'd2 && $past(run_state) == 2'd2 && !bit_tick) |=> $stable(rem.cnt));

endmodule

bind usb_frame_timer ufr_checker i_ufr_checker (
    .clk        (clk),
    .rst        (rst),
    .run_state  (run_state),
    .bit_tick   (bit_tick),
    .ovf_ack    (ovf_ack),
    .sof_pulse  (sof_pulse),
    .fn_msb_flag(fn_msb_flag),
    .rem        (rem),
    .iv         (iv),
    .frame_num  (frame_num)
);

// File: tb/test_usb_frame_timer.sv
module test_usb_frame_timer;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  run_state = 2'd0;
    logic        bit_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        ovf_ack = 1'b0;
    logic        sof_pulse;
    logic        fn_msb_flag;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;

    usb_frame_timer i_usb_frame_timer (
        .clk        (clk),
        .rst        (rst),
        .run_state  (run_state),
        .bit_tick   (bit_tick),
        .wr_en      (wr_en),
        .reg_addr   (reg_addr),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .ovf_ack    (ovf_ack),
        .sof_pulse  (sof_pulse),
        .fn_msb_flag(fn_msb_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic chk_reg(input string tag, input logic [2:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1;
        reg_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset;
        chk_reg("R1 interval", 3'd0, 32'h0000_2EDF);
        chk_reg("R1 remaining", 3'd1, 32'h0);
        chk_reg("R1 number", 3'd2, 32'h0);
        chk_reg("R1 pstart", 3'd3, 32'h0);
        chk_reg("R1 lsthr", 3'd4, 32'h0);
        chk("R1 sof", {31'b0, sof_pulse}, 32'h0);
        chk("R1 flag", {31'b0, fn_msb_flag}, 32'h0);
        chk_reg("R11 unmapped 5", 3'd5, 32'h0);
        chk_reg("R11 unmapped 7", 3'd7, 32'h0);
    endtask

    task automatic t_regwrite;
        wr(3'd0, 32'hFFFF_FFFF);
        chk_reg("R2 strip 15:14", 3'd0, 32'hFFFF_3FFF);
        wr(3'd3, 32'hFFFF_FFFF);
        chk_reg("R3 pstart width", 3'd3, 32'h0000_3FFF);
        wr(3'd4, 32'hFFFF_FFFF);
        chk_reg("R3 lsthr width", 3'd4, 32'h0000_0FFF);
        wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd2, 32'hFFFF_FFFF);
        chk_reg("R4 remaining ro", 3'd1, 32'h0);
        chk_reg("R4 number ro", 3'd2, 32'h0);
    endtask

    task automatic t_run;
        wr(3'd0, 32'h8000_0005);
        run_state = 2'd2;
        bit_tick = 1'b1;
        @(negedge clk);
        chk_reg("R5 entry load", 3'd1, 32'h0000_0005);
        repeat (5) begin
            @(negedge clk);
            chk("R6 no early sof", {31'b0, sof_pulse}, 32'h0);
        end
        chk_reg("R5 count down", 3'd1, 32'h0000_0000);
        @(negedge clk);
        chk("R6 sof at reload", {31'b0, sof_pulse}, 32'h1);
        chk_reg("R7 toggle loaded", 3'd1, 32'h8000_0005);
        chk_reg("R8 number step", 3'd2, 32'h1);
        @(negedge clk);
        chk("R6 sof one cycle", {31'b0, sof_pulse}, 32'h0);
        chk_reg("R5 decrement", 3'd1, 32'h8000_0004);
        bit_tick = 1'b0;
        repeat (3) @(negedge clk);
        chk_reg("R5 hold no strobe", 3'd1, 32'h8000_0004);
        bit_tick = 1'b1;
        wr(3'd0, 32'h0000_0003);
        chk_reg("R6 frame continues", 3'd1, 32'h8000_0003);
        repeat (3) @(negedge clk);
        chk_reg("R6 old span ends", 3'd1, 32'h8000_0000);
        @(negedge clk);
        chk("R6 sof second", {31'b0, sof_pulse}, 32'h1);
        chk_reg("R7 toggle cleared, new span", 3'd1, 32'h0000_0003);
        chk_reg("R8 number two", 3'd2, 32'h2);
        repeat (3) begin
            @(negedge clk);
            chk("R6 period span+1", {31'b0, sof_pulse}, 32'h0);
        end
        @(negedge clk);
        chk("R6 period reached", {31'b0, sof_pulse}, 32'h1);
        chk_reg("R8 number three", 3'd2, 32'h3);
    endtask

    task automatic t_suspend;
        logic [31:0] r0;
        logic [31:0] n0;
        run_state = 2'd3;
        @(negedge clk);
        rd(3'd1, r0);
        rd(3'd2, n0);
        chk("R10 suspend froze count", r0, 32'h0000_0003);
        repeat (8) begin
            @(negedge clk);
            chk("R10 no sof in suspend", {31'b0, sof_pulse}, 32'h0);
        end
        chk_reg("R10 suspend count", 3'd1, r0);
        chk_reg("R10 suspend number", 3'd2, n0);
        run_state = 2'd1;
        repeat (4) @(negedge clk);
        chk_reg("R10 resume count", 3'd1, r0);
        run_state = 2'd2;
        @(negedge clk);
        chk_reg("R5 re-entry reload", 3'd1, 32'h0000_0003);
        chk_reg("R10 number kept", 3'd2, 32'h3);
        run_state = 2'd0;
        @(negedge clk);
        chk_reg("R10 reset clears count", 3'd1, 32'h0);
        chk_reg("R10 reset clears number", 3'd2, 32'h0);
    endtask

    task automatic t_wrap;
        wr(3'd0, 32'h0000_0000);
        run_state = 2'd2;
        bit_tick = 1'b1;
        @(negedge clk);
        chk_reg("R8 start zero", 3'd2, 32'h0);
        repeat (32767) @(negedge clk);
        chk_reg("R8 reach 7fff", 3'd2, 32'h7FFF);
        chk("R9 flag clear before flip", {31'b0, fn_msb_flag}, 32'h0);
        @(negedge clk);
        chk_reg("R8 reach 8000", 3'd2, 32'h8000);
        chk("R9 flag on rise", {31'b0, fn_msb_flag}, 32'h1);
        ovf_ack = 1'b1;
        @(negedge clk);
        ovf_ack = 1'b0;
        chk("R9 ack clears", {31'b0, fn_msb_flag}, 32'h0);
        repeat (32766) @(negedge clk);
        chk_reg("R8 reach ffff", 3'd2, 32'hFFFF);
        chk("R9 flag quiet", {31'b0, fn_msb_flag}, 32'h0);
        ovf_ack = 1'b1;
        @(negedge clk);
        ovf_ack = 1'b0;
        chk_reg("R8 wrap to zero", 3'd2, 32'h0);
        chk("R9 set wins over ack", {31'b0, fn_msb_flag}, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regwrite();
        t_run();
        t_suspend();
        t_wrap();
        done = 1;
    end

    initial begin
        while (!done && cycles < WATCHDOG) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=finish", cycles);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule